// File: doc/BRIEF.md
# Nested Exception Fault Classifier

This block sits beside an exception delivery path and keeps track of the exception currently being delivered. Each newly raised exception is checked against that tracked exception. The result is one of three outcomes. The new exception can be delivered unchanged. It can be replaced by a double fault (vector 8) with a zero error code. It can also be turned into a shutdown pulse, which signals a triple fault, with nothing delivered.

Vectors fall into four classes. Vector 0 and vectors 10 to 13 form the contributory class. Vector 14 is the page-fault class. Vector 8 is the double-fault class. Every other vector is benign. The pair formed by the tracked class and the new class decides the outcome. Software interrupts skip classification completely. The pulse `clear_i` marks the end of delivery and empties the tracker.

Top module: `nested_fault_ctrl`

## Requirements
- R1: After reset, `valid_o`, `shutdown_o`, `vec_o` and `err_o` are zero, and the tracker holds the empty code 0xFF. The first exception after reset is therefore never promoted.
- R2: The outputs are registered. `valid_o` or `shutdown_o` is high for exactly the one cycle after a cycle with `valid_i` high. When `valid_i` is low, neither output rises in the next cycle.
- R3: If the tracked exception is contributory (vector 0 or 10..13) and a new contributory exception arrives, the block delivers vector 8 with error code 0.
- R4: If the tracked exception is a page fault (vector 14) and a new contributory exception or page fault arrives, the block delivers vector 8 with error code 0.
- R5: A page fault that arrives while a contributory exception is tracked is delivered unchanged, with its own error code.
- R6: If the tracked exception is vector 8 and a new exception that is not a software interrupt arrives, the block raises `shutdown_o` for one cycle and keeps `valid_o` low. The tracker then returns to empty.
- R7: A benign vector is delivered unchanged and leaves the tracked exception as it was. Benign means any vector other than 0, 10..14 and 8; 0xFF is benign as an input.
- R8: When `soft_i` is high, the vector and error code pass through unchanged and the tracker is untouched. This holds even while vector 8 is tracked.
- R9: `clear_i` returns the tracker to empty. An exception raised in the same cycle as `clear_i` is classified against the empty tracker.
- R10: After a delivered contributory, page-fault or double-fault exception, the tracker holds the vector that was actually delivered. A promotion therefore makes 8 the tracked vector.
- R11: `valid_o` and `shutdown_o` are never high in the same cycle, and `shutdown_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | New exception or interrupt raised this cycle |
| vec_i | input | 8 | Raised vector number |
| err_i | input | 32 | Raised error code |
| soft_i | input | 1 | Raised event is a software interrupt |
| clear_i | input | 1 | Delivery complete; empties the tracker |
| valid_o | output | 1 | Resulting exception valid (one cycle) |
| vec_o | output | 8 | Resulting vector |
| err_o | output | 32 | Resulting error code |
| shutdown_o | output | 1 | Triple-fault shutdown pulse |

## Verification
The bench checks the class pairings at their edges.

- **Vector 0 followed by vector 0.** A design that treats 0 as the empty code would miss this promotion.
- **A benign vector between two contributory ones.** A design that updates the tracker on every vector would lose the promotion on the third exception.
- **A contributory vector after a page fault that itself followed a contributory one.** A design that does not record the delivered page fault would deliver the contributory vector unchanged instead of vector 8.
- **A software interrupt while vector 8 is tracked, and `clear_i` in the same cycle as a raise.** A wrong design would either shut down on the software interrupt or promote against a tracker that had already been cleared.
- **Shutdown itself.** The bench checks that the shutdown pulse never comes with a valid output and that the tracker is empty afterwards.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {
    CLS_BENIGN,
    CLS_CONTRIB,
    CLS_PAGE,
    CLS_DOUBLE
  } fault_cls_e;

  typedef enum logic [1:0] {
    ACT_PASS,
    ACT_PROMOTE,
    ACT_SHUTDOWN
  } fault_act_e;
endpackage

// File: rtl/nfc_classify.sv
module nfc_classify
  import nfc_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int DF_VEC     = 8,
  parameter int PF_VEC     = 14,
  parameter int CONTRIB_LO = 10,
  parameter int CONTRIB_HI = 13
) (
  input  logic [VEC_W-1:0] vec_i,
  output fault_cls_e       cls_o
);
  localparam logic [VEC_W-1:0] DF = VEC_W'(DF_VEC);
  localparam logic [VEC_W-1:0] PF = VEC_W'(PF_VEC);
  localparam logic [VEC_W-1:0] LO = VEC_W'(CONTRIB_LO);
  localparam logic [VEC_W-1:0] HI = VEC_W'(CONTRIB_HI);

  logic is_contrib;
  assign is_contrib = (vec_i == '0) || ((vec_i >= LO) && (vec_i <= HI));

  always_comb begin
    if (is_contrib)        cls_o = CLS_CONTRIB;
    else if (vec_i == PF)  cls_o = CLS_PAGE;
    else if (vec_i == DF)  cls_o = CLS_DOUBLE;
    else                   cls_o = CLS_BENIGN;
  end
endmodule

// File: rtl/nfc_decide.sv
module nfc_decide
  import nfc_pkg::*;
(
  input  logic       soft_i,
  input  fault_cls_e prev_cls_i,
  input  fault_cls_e new_cls_i,
  output fault_act_e act_o,
  output logic       track_we_o
);
  logic promote;
  assign promote = ((prev_cls_i == CLS_CONTRIB) && (new_cls_i == CLS_CONTRIB)) ||
                   ((prev_cls_i == CLS_PAGE) &&
                    ((new_cls_i == CLS_CONTRIB) || (new_cls_i == CLS_PAGE)));

  always_comb begin
    act_o      = ACT_PASS;
    track_we_o = 1'b0;
    if (soft_i) begin
      act_o      = ACT_PASS;
      track_we_o = 1'b0;
    end else if (prev_cls_i == CLS_DOUBLE) begin
      act_o      = ACT_SHUTDOWN;
      track_we_o = 1'b1;
    end else if (promote) begin
      act_o      = ACT_PROMOTE;
      track_we_o = 1'b1;
    end else begin
      act_o      = ACT_PASS;
      track_we_o = (new_cls_i != CLS_BENIGN);
    end
  end
endmodule

// File: rtl/nfc_tracker.sv
module nfc_tracker #(
  parameter int VEC_W    = 8,
  parameter int NONE_VEC = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             we_i,
  input  logic [VEC_W-1:0] wdata_i,
  output logic [VEC_W-1:0] prev_o
);
  localparam logic [VEC_W-1:0] NONE = VEC_W'(NONE_VEC);

  logic [VEC_W-1:0] prev_q;

  // clear takes effect before a same-cycle classification
  assign prev_o = clear_i ? NONE : prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_q <= NONE;
    else if (we_i)     prev_q <= wdata_i;
    else if (clear_i)  prev_q <= NONE;
  end
endmodule

// File: rtl/nested_fault_ctrl.sv
module nested_fault_ctrl
  import nfc_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int ERR_W      = 32,
  parameter int DF_VEC     = 8,
  parameter int PF_VEC     = 14,
  parameter int CONTRIB_LO = 10,
  parameter int CONTRIB_HI = 13,
  parameter int NONE_VEC   = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             soft_i,
  input  logic             clear_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [ERR_W-1:0] err_o,
  output logic             shutdown_o
);
  localparam logic [VEC_W-1:0] DF   = VEC_W'(DF_VEC);
  localparam logic [VEC_W-1:0] NONE = VEC_W'(NONE_VEC);

  logic [VEC_W-1:0] prev_vec;
  fault_cls_e       cls_arr [2];
  logic [VEC_W-1:0] cls_in  [2];
  fault_act_e       act;
  logic             track_we;
  logic [VEC_W-1:0] track_wdata;

  assign cls_in[0] = prev_vec;
  assign cls_in[1] = vec_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    nfc_classify #(
      .VEC_W(VEC_W), .DF_VEC(DF_VEC), .PF_VEC(PF_VEC),
      .CONTRIB_LO(CONTRIB_LO), .CONTRIB_HI(CONTRIB_HI)
    ) u_cls (
      .vec_i(cls_in[g]),
      .cls_o(cls_arr[g])
    );
  end

  nfc_decide u_decide (
    .soft_i    (soft_i),
    .prev_cls_i(cls_arr[0]),
    .new_cls_i (cls_arr[1]),
    .act_o     (act),
    .track_we_o(track_we)
  );

  always_comb begin
    case (act)
      ACT_PROMOTE:  track_wdata = DF;
      ACT_SHUTDOWN: track_wdata = NONE;
      default:      track_wdata = vec_i;
    endcase
  end

  nfc_tracker #(.VEC_W(VEC_W), .NONE_VEC(NONE_VEC)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .we_i   (valid_i && track_we),
    .wdata_i(track_wdata),
    .prev_o (prev_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      shutdown_o <= 1'b0;
      vec_o      <= '0;
      err_o      <= '0;
    end else begin
      valid_o    <= valid_i && (act != ACT_SHUTDOWN);
      shutdown_o <= valid_i && (act == ACT_SHUTDOWN);
      if (valid_i && act == ACT_PROMOTE) begin
        vec_o <= DF;
        err_o <= '0;
      end else if (valid_i && act == ACT_PASS) begin
        vec_o <= vec_i;
        err_o <= err_i;
      end
    end
  end
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
  parameter int VEC_W  = 8,
  parameter int ERR_W  = 32,
  parameter int DF_VEC = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [VEC_W-1:0] vec_i,
  input logic [ERR_W-1:0] err_i,
  input logic             soft_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [ERR_W-1:0] err_o,
  input logic             shutdown_o
);
  localparam logic [VEC_W-1:0] DF = VEC_W'(DF_VEC);

  a_r2_raise_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (valid_o || shutdown_o));

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !shutdown_o));

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && shutdown_o));

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> !shutdown_o);

  a_r8_soft_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && soft_i) |=> (valid_o && vec_o == $past(vec_i) && err_o == $past(err_i)));

  // R3/R4: promotion clears the error code
  a_r3_promote_zero_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vec_i != DF) |=> ((valid_o && vec_o == DF) -> err_o == '0));
endmodule

bind nested_fault_ctrl nfc_checker #(
  .VEC_W(VEC_W), .ERR_W(ERR_W), .DF_VEC(DF_VEC)
) u_nfc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .vec_i(vec_i),
  .err_i(err_i), .soft_i(soft_i), .valid_o(valid_o), .vec_o(vec_o),
  .err_o(err_o), .shutdown_o(shutdown_o)
);

// File: tb/nested_fault_ctrl_tb.sv
module nested_fault_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  vec_i = '0;
  logic [31:0] err_i = '0;
  logic        soft_i = 1'b0;
  logic        clear_i = 1'b0;
  logic        valid_o, shutdown_o;
  logic [7:0]  vec_o;
  logic [31:0] err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nested_fault_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .vec_i(vec_i),
    .err_i(err_i), .soft_i(soft_i), .clear_i(clear_i), .valid_o(valid_o),
    .vec_o(vec_o), .err_o(err_o), .shutdown_o(shutdown_o)
  );

  task automatic expect_out(input logic ev, input logic [7:0] evec,
                            input logic [31:0] eerr, input logic esd,
                            input string tag);
    checks++;
    if (valid_o !== ev || shutdown_o !== esd ||
        (ev && (vec_o !== evec || err_o !== eerr))) begin
      errors++;
      $display("FAIL %s: got valid=%0b vec=%0d err=%0h sd=%0b exp valid=%0b vec=%0d err=%0h sd=%0b",
               tag, valid_o, vec_o, err_o, shutdown_o, ev, evec, eerr, esd);
    end
  endtask

  // drive at negedge, output registered at next posedge, sample at following negedge
  task automatic raise(input logic [7:0] v, input logic [31:0] e, input logic s,
                       input logic clr, input logic ev, input logic [7:0] evec,
                       input logic [31:0] eerr, input logic esd, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1; vec_i = v; err_i = e; soft_i = s; clear_i = clr;
    @(negedge clk_i);
    valid_i = 1'b0; soft_i = 1'b0; clear_i = 1'b0;
    expect_out(ev, evec, eerr, esd, tag);
  endtask

  task automatic clear_trk();
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic t_reset();
    expect_out(1'b0, 8'd0, 32'd0, 1'b0, "R1 reset outputs");
    checks++;
    if (vec_o !== 8'd0 || err_o !== 32'd0) begin
      errors++;
      $display("FAIL R1: vec=%0d err=%0h exp 0 0", vec_o, err_o);
    end
    raise(8'd11, 32'h21, 1'b0, 1'b0, 1'b1, 8'd11, 32'h21, 1'b0, "R1 first not promoted");
  endtask

  task automatic t_contrib_pair();
    clear_trk();
    raise(8'd13, 32'h5, 1'b0, 1'b0, 1'b1, 8'd13, 32'h5, 1'b0, "R3 first contributory");
    raise(8'd0, 32'h7, 1'b0, 1'b0, 1'b1, 8'd8, 32'h0, 1'b0, "R3 contrib pair promotes");
    raise(8'd10, 32'h9, 1'b0, 1'b0, 1'b0, 8'd0, 32'h0, 1'b1, "R6 after double fault shutdown");
    @(negedge clk_i);
    expect_out(1'b0, 8'd0, 32'd0, 1'b0, "R11 shutdown single cycle");
    raise(8'd11, 32'h3, 1'b0, 1'b0, 1'b1, 8'd11, 32'h3, 1'b0, "R6 tracker empty after shutdown");
  endtask

  task automatic t_page();
    clear_trk();
    raise(8'd14, 32'h2, 1'b0, 1'b0, 1'b1, 8'd14, 32'h2, 1'b0, "R4 first page fault");
    raise(8'd14, 32'h3, 1'b0, 1'b0, 1'b1, 8'd8, 32'h0, 1'b0, "R4 page after page");
    clear_trk();
    raise(8'd14, 32'h2, 1'b0, 1'b0, 1'b1, 8'd14, 32'h2, 1'b0, "R4 page again");
    raise(8'd12, 32'h4, 1'b0, 1'b0, 1'b1, 8'd8, 32'h0, 1'b0, "R4 contrib after page");
  endtask

  task automatic t_contrib_then_page();
    clear_trk();
    raise(8'd10, 32'h1, 1'b0, 1'b0, 1'b1, 8'd10, 32'h1, 1'b0, "R5 contrib");
    raise(8'd14, 32'h6, 1'b0, 1'b0, 1'b1, 8'd14, 32'h6, 1'b0, "R5 page after contrib unchanged");
    raise(8'd11, 32'h8, 1'b0, 1'b0, 1'b1, 8'd8, 32'h0, 1'b0, "R10 page became tracked");
  endtask

  task automatic t_benign();
    clear_trk();
    raise(8'd12, 32'h1, 1'b0, 1'b0, 1'b1, 8'd12, 32'h1, 1'b0, "R7 contrib");
    raise(8'd3, 32'h9, 1'b0, 1'b0, 1'b1, 8'd3, 32'h9, 1'b0, "R7 benign unchanged");
    raise(8'd255, 32'hA, 1'b0, 1'b0, 1'b1, 8'd255, 32'hA, 1'b0, "R7 0xFF benign");
    raise(8'd13, 32'hB, 1'b0, 1'b0, 1'b1, 8'd8, 32'h0, 1'b0, "R7 tracker kept contrib");
  endtask

  task automatic t_soft();
    clear_trk();
    raise(8'd8, 32'hC, 1'b0, 1'b0, 1'b1, 8'd8, 32'hC, 1'b0, "R10 double fault tracked");
    raise(8'h80, 32'h1, 1'b1, 1'b0, 1'b1, 8'h80, 32'h1, 1'b0, "R8 soft with df tracked");
    raise(8'd13, 32'h2, 1'b1, 1'b0, 1'b1, 8'd13, 32'h2, 1'b0, "R8 soft contrib vector");
    raise(8'd5, 32'h3, 1'b0, 1'b0, 1'b0, 8'd0, 32'h0, 1'b1, "R8 tracker untouched by soft");
  endtask

  task automatic t_clear();
    clear_trk();
    raise(8'd10, 32'h1, 1'b0, 1'b0, 1'b1, 8'd10, 32'h1, 1'b0, "R9 contrib");
    clear_trk();
    raise(8'd12, 32'h2, 1'b0, 1'b0, 1'b1, 8'd12, 32'h2, 1'b0, "R9 clear empties tracker");
    raise(8'd11, 32'h3, 1'b0, 1'b1, 1'b1, 8'd11, 32'h3, 1'b0, "R9 same-cycle clear");
    raise(8'd0, 32'h4, 1'b0, 1'b0, 1'b1, 8'd8, 32'h0, 1'b0, "R9 raise with clear tracked");
  endtask

  task automatic t_zero_vec();
    clear_trk();
    raise(8'd0, 32'h5, 1'b0, 1'b0, 1'b1, 8'd0, 32'h5, 1'b0, "R3 vector 0 first");
    raise(8'd0, 32'h6, 1'b0, 1'b0, 1'b1, 8'd8, 32'h0, 1'b0, "R3 vector 0 pair");
    @(negedge clk_i);
    expect_out(1'b0, 8'd0, 32'd0, 1'b0, "R2 idle no output");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset_pre();
    rst_ni = 1'b1;
    t_reset();
    t_contrib_pair();
    t_page();
    t_contrib_then_page();
    t_benign();
    t_soft();
    t_clear();
    t_zero_vec();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset_pre();
    expect_out(1'b0, 8'd0, 32'd0, 1'b0, "R1 in reset");
  endtask
endmodule